// File: doc/BRIEF.md
# CAN Frame Timestamp Unit

This block keeps a free-running timebase for a CAN controller and hands the protocol engine a timestamp for each frame. The timebase is a counter that advances once every sixteen CAN clocks through a prescale divider. It wraps silently at the top of its range and raises no flag when it does.

When the protocol engine reports that a frame has started, the block latches the counter value that is present in that cycle and holds it as a pending stamp. The stamp is released to the message element only if the engine later reports successful completion. It is dropped if the engine reports an error or a lost arbitration. Software reaches the block through a small register port. That port carries a controller-enable bit, a self-clearing command that zeroes the counter, and a read path for the live counter value.

Top module: `can_frame_timestamp`

## Requirements
- R1: While enabled, the counter advances by one every 16 clocks. The first advance comes exactly 16 clocks after the clock edge that clears the counter or enables the block.
- R2: A write to address 1 with bit 0 set zeroes the counter and the prescale divider at that clock edge. If that edge would also have advanced the counter, the clear takes priority.
- R3: `reg_rdata` is registered and follows `reg_raddr` one cycle later. Address 1 returns the counter in bits 31:16 and zero in bits 15:0, so the clear bit always reads 0. Address 0 returns the enable bit in bit 0 and zero elsewhere. Any other address returns zero.
- R4: A write to address 0 sets the enable bit from bit 0 of the write data. Writing 0 clears the counter. While the block is disabled, the counter is held at zero and the frame strobes are ignored.
- R5: The counter wraps silently from its maximum value to zero and then keeps counting.
- R6: A start-of-frame strobe, while enabled, latches the counter value present in that same cycle as the pending stamp.
- R7: A success strobe that finds a pending stamp makes `stamp_valid` high for exactly one cycle, in the cycle after the strobe. `stamp_value` then carries the latched value.
- R8: An error strobe discards the pending stamp. If an error strobe and a success strobe arrive in the same cycle, no pulse is produced. A success strobe with nothing pending produces no pulse.
- R9: A new start-of-frame strobe overwrites any pending stamp. If a start-of-frame strobe and a success strobe arrive in the same cycle, the old stamp is committed and the new one is armed.
- R10: After reset, the counter is 0, the block is disabled, `stamp_valid` is 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 32 | Registered read data |
| sof_strobe | input | 1 | Start of frame seen (identifier begins) |
| done_ok | input | 1 | Frame completed successfully |
| done_err | input | 1 | Frame aborted, errored or arbitration lost |
| cnt_live | output | 16 | Live timestamp counter |
| stamp_valid | output | 1 | One-cycle pulse: committed stamp available |
| stamp_value | output | 16 | Committed timestamp |

## Verification
Every result appears one clock after the edge that causes it. The counter shows a clear or an advance in the cycle after that edge. Read data reflects the address and state one edge earlier. The stamp pulse appears in the cycle after the success strobe, and it carries the counter value that was present on the start-of-frame strobe. The bench drives inputs on the falling edge and samples on the next falling edge. A cycle-accurate reference model, advanced on the rising edge, queues each expected stamp, and the monitor compares every output against that model each cycle. Directed checks use the same one-cycle alignment for the prescale boundary, clear priority and wrap.

// File: rtl/can_ts_pkg.sv
package can_ts_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_STAMP = 2'd1;
  localparam int BIT_ENABLE = 0;
  localparam int BIT_CLEAR  = 0;

  typedef struct packed {
    logic sof;
    logic ok;
    logic err;
  } frame_evt_t;
endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  generate
    if (DIV_W == 0) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || clr) div_q <= '0;
        else            div_q <= div_q + 1'b1;
      end
      assign tick = &div_q;

      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
  // R1
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick) |=> cnt == $past(cnt));
  // R5
  silent_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && tick && (&cnt)) |=> cnt == '0);
endmodule

// File: rtl/ts_capture.sv
module ts_capture import can_ts_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  frame_evt_t       evt,
  input  logic [CNT_W-1:0] cnt,
  output logic             stamp_valid,
  output logic [CNT_W-1:0] stamp_value
);
  logic             pend_vld;
  logic [CNT_W-1:0] pend_val;
  logic             commit;

  assign commit = en && evt.ok && !evt.err && pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld    <= 1'b0;
      pend_val    <= '0;
      stamp_valid <= 1'b0;
      stamp_value <= '0;
    end else begin
      stamp_valid <= commit;
      if (commit) stamp_value <= pend_val;
      if (!en)                      pend_vld <= 1'b0;
      else if (evt.sof)             pend_vld <= 1'b1;
      else if (evt.ok || evt.err)   pend_vld <= 1'b0;
      if (en && evt.sof) pend_val <= cnt;
    end
  end

  // R7
  pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
    stamp_valid |-> ($past(evt.ok) && !$past(evt.err)));
  // R8
  error_drops_chk: assert property (@(posedge clk) disable iff (rst)
    evt.err |=> !stamp_valid);
  // R4
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !stamp_valid);
  // R6
  sof_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (en && evt.sof) |=> pend_val == $past(cnt));
endmodule

// File: rtl/ts_regs.sv
module ts_regs import can_ts_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  input  logic [CNT_W-1:0]  cnt,
  output logic              en_q,
  output logic              clr_cmd,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_LSB = DATA_W - CNT_W;

  logic wr_ctrl;
  logic wr_stamp;

  assign wr_ctrl  = reg_wr && (reg_waddr == ADDR_CTRL);
  assign wr_stamp = reg_wr && (reg_waddr == ADDR_STAMP);
  assign clr_cmd  = (wr_stamp && reg_wdata[BIT_CLEAR]) ||
                    (wr_ctrl && !reg_wdata[BIT_ENABLE]);

  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (wr_ctrl) en_q <= reg_wdata[BIT_ENABLE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_raddr)
        ADDR_CTRL:  reg_rdata[BIT_ENABLE] <= en_q;
        ADDR_STAMP: reg_rdata[DATA_W-1:CNT_LSB] <= cnt;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  generate
    if (CNT_LSB > 0) begin : g_low_chk
      // R3
      low_half_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_raddr == ADDR_STAMP) |=> reg_rdata[CNT_LSB-1:0] == '0);
    end
  endgenerate
  // R4
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> en_q == $past(reg_wdata[BIT_ENABLE]));
endmodule

// File: rtl/can_frame_timestamp.sv
module can_frame_timestamp import can_ts_pkg::*; #(
  parameter int CNT_W      = 16,
  parameter int PRESCALE_W = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sof_strobe,
  input  logic              done_ok,
  input  logic              done_err,
  output logic [CNT_W-1:0]  cnt_live,
  output logic              stamp_valid,
  output logic [CNT_W-1:0]  stamp_value
);
  logic       en_q;
  logic       clr_cmd;
  logic       clr_all;
  logic       tick;
  frame_evt_t evt;

  assign evt     = '{sof: sof_strobe, ok: done_ok, err: done_err};
  assign clr_all = clr_cmd || !en_q;

  ts_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .cnt(cnt_live),
    .en_q(en_q), .clr_cmd(clr_cmd), .reg_rdata(reg_rdata)
  );

  ts_prescaler #(.DIV_W(PRESCALE_W)) u_presc (
    .clk(clk), .rst(rst), .clr(clr_all), .tick(tick)
  );

  ts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_all), .tick(tick), .cnt(cnt_live)
  );

  ts_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst(rst), .en(en_q), .evt(evt), .cnt(cnt_live),
    .stamp_valid(stamp_valid), .stamp_value(stamp_value)
  );

  // R4
  disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> cnt_live == '0);
endmodule

// File: tb/can_frame_timestamp_tb.sv
`timescale 1ns/1ps
module can_frame_timestamp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic        sof_strobe = 1'b0, done_ok = 1'b0, done_err = 1'b0;
  logic [31:0] reg_rdata, w_rdata;
  logic [15:0] cnt_live, stamp_value, w_cnt, w_stamp;
  logic        stamp_valid, w_valid;

  always #5 clk = ~clk;

  can_frame_timestamp u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .sof_strobe(sof_strobe), .done_ok(done_ok), .done_err(done_err),
    .cnt_live(cnt_live), .stamp_valid(stamp_valid), .stamp_value(stamp_value)
  );

  can_frame_timestamp #(.PRESCALE_W(0)) u_wrap (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(w_rdata),
    .sof_strobe(sof_strobe), .done_ok(done_ok), .done_err(done_err),
    .cnt_live(w_cnt), .stamp_valid(w_valid), .stamp_value(w_stamp)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Reference model, advanced on the rising edge
  bit          m_en = 0, m_pv = 0, m_pulse = 0;
  int          m_div = 0;
  logic [15:0] m_cnt = '0, m_pval = '0;
  logic [31:0] m_rdata = '0;
  logic [15:0] exp_q[$];

  always @(posedge clk) begin
    bit wr_c, clr, commit;
    if (rst) begin
      m_en = 0; m_div = 0; m_cnt = '0; m_pv = 0; m_pval = '0;
      m_pulse = 0; m_rdata = '0; exp_q.delete();
    end else begin
      m_rdata = (reg_raddr == 2'd0) ? {31'b0, m_en} :
                (reg_raddr == 2'd1) ? {m_cnt, 16'h0} : 32'h0;
      wr_c   = reg_wr && reg_waddr == 2'd0;
      clr    = (wr_c && !reg_wdata[0]) || (reg_wr && reg_waddr == 2'd1 && reg_wdata[0]) || !m_en;
      commit = m_en && done_ok && !done_err && m_pv;
      m_pulse = commit;
      if (commit) exp_q.push_back(m_pval);
      if (m_en && sof_strobe) m_pval = m_cnt;
      if (!m_en) m_pv = 0;
      else if (sof_strobe) m_pv = 1;
      else if (done_ok || done_err) m_pv = 0;
      if (clr) begin
        m_cnt = '0; m_div = 0;
      end else begin
        if (m_div == 15) m_cnt = m_cnt + 16'd1;
        m_div = (m_div + 1) % 16;
      end
      if (wr_c) m_en = reg_wdata[0];
    end
  end

  // Monitor / scoreboard, on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R1 counter vs model", {16'h0, cnt_live}, {16'h0, m_cnt});
      check("R3 read data vs model", reg_rdata, m_rdata);
      check("R7 pulse presence", {31'b0, stamp_valid}, {31'b0, m_pulse});
      if (stamp_valid) begin
        if (exp_q.size() == 0) check("R8 unexpected stamp", 32'd1, 32'd0);
        else check("R7 stamp value", {16'h0, stamp_value}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic strobe(input bit s, input bit o, input bit e);
    sof_strobe = s; done_ok = o; done_err = e;
    @(negedge clk);
    sof_strobe = 1'b0; done_ok = 1'b0; done_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 cnt", {16'h0, cnt_live}, 32'h0);
    check("R10 valid", {31'b0, stamp_valid}, 32'h0);
    check("R10 rdata", reg_rdata, 32'h0);
    // R4 disabled: held at zero, strobes ignored
    repeat (20) @(negedge clk);
    strobe(1, 0, 0); strobe(0, 1, 0);
    check("R4 disabled no pulse", {31'b0, stamp_valid}, 32'h0);
    check("R4 disabled hold", {16'h0, cnt_live}, 32'h0);
    // R1 first advance 16 clocks after enable
    reg_write(2'd0, 32'h1);
    repeat (15) @(negedge clk);
    check("R1 before 16th clock", {16'h0, cnt_live}, 32'h0);
    @(negedge clk);
    check("R1 at 16th clock", {16'h0, cnt_live}, 32'h1);
    // R3 reads
    reg_raddr = 2'd0; @(negedge clk);
    check("R3 ctrl read", reg_rdata, 32'h1);
    reg_raddr = 2'd1; repeat (100) @(negedge clk);
    check("R3 low half zero", {16'h0, reg_rdata[15:0]}, 32'h0);
    reg_raddr = 2'd2; @(negedge clk);
    check("R3 unused address", reg_rdata, 32'h0);
    reg_raddr = 2'd1;
    // R6 R7 basic frame
    a = cnt_live; strobe(1, 0, 0);
    repeat (50) @(negedge clk);
    strobe(0, 1, 0);
    check("R7 pulse", {31'b0, stamp_valid}, 32'h1);
    check("R6 value", {16'h0, stamp_value}, {16'h0, a});
    @(negedge clk);
    check("R7 single cycle", {31'b0, stamp_valid}, 32'h0);
    // R8 error discards, ok+err together, ok with nothing pending
    strobe(1, 0, 0); repeat (20) @(negedge clk);
    strobe(0, 0, 1); strobe(0, 1, 0);
    check("R8 after error", {31'b0, stamp_valid}, 32'h0);
    strobe(1, 0, 0); repeat (20) @(negedge clk);
    strobe(0, 1, 1);
    check("R8 ok with err", {31'b0, stamp_valid}, 32'h0);
    strobe(0, 1, 0);
    check("R8 nothing pending", {31'b0, stamp_valid}, 32'h0);
    // R9 overwrite and sof+ok in one cycle
    strobe(1, 0, 0); repeat (40) @(negedge clk);
    b = cnt_live; strobe(1, 0, 0); repeat (40) @(negedge clk);
    strobe(0, 1, 0);
    check("R9 overwrite", {16'h0, stamp_value}, {16'h0, b});
    a = cnt_live; strobe(1, 0, 0); repeat (40) @(negedge clk);
    b = cnt_live; strobe(1, 1, 0);
    check("R9 commit old", {16'h0, stamp_value}, {16'h0, a});
    repeat (40) @(negedge clk);
    strobe(0, 1, 0);
    check("R9 arm new", {16'h0, stamp_value}, {16'h0, b});
    // R2 clear on the edge that would advance
    while (m_div != 15) @(negedge clk);
    reg_write(2'd1, 32'h1);
    check("R2 clear wins", {16'h0, cnt_live}, 32'h0);
    repeat (15) @(negedge clk);
    check("R2 divider cleared", {16'h0, cnt_live}, 32'h0);
    @(negedge clk);
    check("R2 restart", {16'h0, cnt_live}, 32'h1);
    // R4 disable clears, strobes ignored
    repeat (40) @(negedge clk);
    strobe(1, 0, 0);
    reg_write(2'd0, 32'h0);
    check("R4 disable clears", {16'h0, cnt_live}, 32'h0);
    strobe(0, 1, 0);
    check("R4 pending dropped", {31'b0, stamp_valid}, 32'h0);
    reg_raddr = 2'd0; @(negedge clk);
    check("R4 enable reads 0", reg_rdata, 32'h0);
    // R5 wrap on the undivided instance
    reg_write(2'd0, 32'h1);
    reg_write(2'd1, 32'h1);
    check("R5 wrap start", {16'h0, w_cnt}, 32'h0);
    repeat (65535) @(negedge clk);
    check("R5 at max", {16'h0, w_cnt}, 32'hFFFF);
    @(negedge clk);
    check("R5 wrapped", {16'h0, w_cnt}, 32'h0);
    @(negedge clk);
    check("R5 continues", {16'h0, w_cnt}, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule